// File: doc/BRIEF.md
# DRAM Row-Open Access Sequencer

This block drives the address strobes of an external bus that is shared by three kinds of space: DRAM, burst ROM and ordinary external memory. Each accepted request names its space, a row, a column and a keep-row bit. A DRAM request whose row is already open costs only two column cycles. A DRAM request to a closed or different row costs four cycles: a precharge cycle, a row cycle and two column cycles.

An ordinary external access takes two cycles and never pulses the column strobe. With the keep-row bit at 0, it also releases the row strobe and forgets the open row. A burst ROM access takes two cycles and leaves the row strobe and the open row untouched, so a DRAM access that follows can still run as a burst.

Requests arrive on a valid/ready port. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The request fields are sampled only on that edge, so the source must hold them steady while `req_valid` is high and `req_ready` is low. `req_ready` does not depend on `req_valid`. It is high when the block is idle and during the final cycle of an access, which lets accesses chain back to back with no gap cycle.

Top module: `dram_row_seq`

## Requirements
- R1: While reset is applied, and straight after it, `ras_n`=1, `cas_n`=1, `req_ready`=1, `busy`=0, `done`=0 and `addr_out`=0.
- R2: A request is taken on a rising edge with `req_valid`=1 and `req_ready`=1. `req_ready` is 1 when idle and in the last cycle of an access, and 0 in every other cycle. When idle, `addr_out`=0 and `ras_n` equals the inverse of the row-open state.
- R3: A DRAM request (`req_space`=2'b01) to a closed row, or to a row other than the open one, runs four cycles starting on the cycle after acceptance:
  - `ras_n` is 1,0,0,0 over the four cycles;
  - `cas_n` is 1,1,1,0;
  - `addr_out` is row, row, column, column.

  After it, that row is open.
- R4: A DRAM request to the open row runs two cycles: `ras_n`=0 in both, `cas_n`=1 then 0, and `addr_out`=column in both.
- R5: `cas_n` is low only while `ras_n` is low, and only for one cycle at a time.
- R6: An external request (`req_space`=2'b00 or 2'b11) with `req_keep`=0 runs two cycles with `ras_n`=1, `cas_n`=1 and `addr_out`=column. It closes the row, so the next DRAM request runs as in R3.
- R7: An external request with `req_keep`=1 runs two cycles with `cas_n`=1 and `addr_out`=column. The row strobe and the open row are unchanged.
- R8: A burst ROM request (`req_space`=2'b10) runs two cycles with `cas_n`=1 and `addr_out`=column. The row strobe and the open row are unchanged whatever `req_keep` is.
- R9: `done` is 1 in exactly the last cycle of each access. `busy` is 1 in every cycle of an access.
- R10: The first DRAM request after reset always runs the full four-cycle sequence of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_space | input | 2 | 00 external, 01 DRAM, 10 burst ROM, 11 external |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_keep | input | 1 | 1: an external access keeps the row open |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_out | output | max(ROW_W,COL_W) | Multiplexed address |
| busy | output | 1 | Access in progress |
| done | output | 1 | Last cycle of an access |

## Verification
A wrong open-row flag or a wrong stored row shows up as a DRAM access of the wrong length. A burst runs where a precharge was due, or a precharge runs where a burst was due. This is visible at the ports on the first cycle after the next DRAM request is taken, as a wrong `ras_n` or `addr_out`, and again one cycle later on `req_ready`. A stuck or skipped sequencer state shows within one cycle as a misplaced `cas_n` pulse, a wrong `done`, or `req_ready` rising too early. The bench's model compares every port on every cycle, so the first wrong cycle is the one reported.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ROW, ST_COL1, ST_COL2, ST_EXT1, ST_EXT2
  } seq_state_t;

  localparam logic [1:0] SPACE_EXT  = 2'd0;
  localparam logic [1:0] SPACE_DRAM = 2'd1;
  localparam logic [1:0] SPACE_ROM  = 2'd2;
endpackage

// File: rtl/dram_open_row.sv
module dram_open_row #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [ROW_W-1:0] set_row_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic             row_open_o,
  output logic             hit_o
);
  logic [ROW_W-1:0] open_row_q;
  logic             open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      open_row_q <= '0;
    end else if (clr_i) begin
      open_q <= 1'b0;
    end else if (set_i) begin
      open_q     <= 1'b1;
      open_row_q <= set_row_i;
    end
  end

  assign row_open_o = open_q;
  assign hit_o      = open_q && (cmp_row_i == open_row_q);

  AST_SET_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_i && clr_i)); // R3
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_space,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_keep,
  input  logic             req_hit,
  output logic             req_ready,
  output logic             accept_o,
  output logic             open_set_o,
  output logic             open_clr_o,
  output seq_state_t       state_o,
  output logic [ROW_W-1:0] lat_row_o,
  output logic [COL_W-1:0] lat_col_o
);
  seq_state_t state_q, state_d;
  logic is_dram, is_rom, is_ext;

  assign is_dram   = (req_space == SPACE_DRAM);
  assign is_rom    = (req_space == SPACE_ROM);
  assign is_ext    = !is_dram && !is_rom;
  assign req_ready = (state_q == ST_IDLE) || (state_q == ST_COL2) ||
                     (state_q == ST_EXT2);
  assign accept_o  = req_valid && req_ready;

  assign open_clr_o = accept_o && ((is_dram && !req_hit) || (is_ext && !req_keep));
  assign open_set_o = (state_q == ST_ROW);

  always_comb begin
    state_d = state_q;
    if (accept_o) begin
      if (is_dram) state_d = req_hit ? ST_COL1 : ST_PRE;
      else         state_d = ST_EXT1;
    end else begin
      case (state_q)
        ST_PRE:  state_d = ST_ROW;
        ST_ROW:  state_d = ST_COL1;
        ST_COL1: state_d = ST_COL2;
        ST_EXT1: state_d = ST_EXT2;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lat_row_o <= '0;
      lat_col_o <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        lat_row_o <= req_row;
        lat_col_o <= req_col;
      end
    end
  end

  assign state_o = state_q;

  AST_PRE_THEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE) |=> (state_q == ST_ROW)); // R3
  AST_EXT_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXT1) |=> (state_q == ST_EXT2)); // R6
endmodule

// File: rtl/dram_pin_drive.sv
module dram_pin_drive
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 8
) (
  input  seq_state_t       state_i,
  input  logic             row_open_i,
  input  logic [ROW_W-1:0] lat_row_i,
  input  logic [COL_W-1:0] lat_col_i,
  output logic             ras_n,
  output logic             cas_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr_out,
  output logic             done,
  output logic             busy
);
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  logic [ADDR_W-1:0] row_ext, col_ext;

  assign row_ext = ADDR_W'(lat_row_i);
  assign col_ext = ADDR_W'(lat_col_i);

  always_comb begin
    ras_n    = !row_open_i;
    cas_n    = 1'b1;
    addr_out = '0;
    case (state_i)
      ST_PRE:  begin ras_n = 1'b1; addr_out = row_ext; end
      ST_ROW:  begin ras_n = 1'b0; addr_out = row_ext; end
      ST_COL1: addr_out = col_ext;
      ST_COL2: begin cas_n = 1'b0; addr_out = col_ext; end
      ST_EXT1, ST_EXT2: addr_out = col_ext;
      default: ;
    endcase
  end

  assign done = (state_i == ST_COL2) || (state_i == ST_EXT2);
  assign busy = (state_i != ST_IDLE);
endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 8,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_space,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_keep,
  output logic              ras_n,
  output logic              cas_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic              busy,
  output logic              done
);
  seq_state_t       state;
  logic             accept, open_set, open_clr, row_open, hit;
  logic [ROW_W-1:0] lat_row;
  logic [COL_W-1:0] lat_col;

  dram_open_row #(.ROW_W(ROW_W)) u_open (
    .clk(clk), .rst_n(rst_n), .set_i(open_set), .clr_i(open_clr),
    .set_row_i(lat_row), .cmp_row_i(req_row),
    .row_open_o(row_open), .hit_o(hit)
  );

  dram_seq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
    .req_row(req_row), .req_col(req_col), .req_keep(req_keep), .req_hit(hit),
    .req_ready(req_ready), .accept_o(accept), .open_set_o(open_set),
    .open_clr_o(open_clr), .state_o(state), .lat_row_o(lat_row),
    .lat_col_o(lat_col)
  );

  dram_pin_drive #(.ROW_W(ROW_W), .COL_W(COL_W)) u_pins (
    .state_i(state), .row_open_i(row_open), .lat_row_i(lat_row),
    .lat_col_i(lat_col), .ras_n(ras_n), .cas_n(cas_n), .addr_out(addr_out),
    .done(done), .busy(busy)
  );

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n); // R5
  AST_CAS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |=> cas_n); // R5
  AST_ROW_BEFORE_COL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> cas_n); // R3
  AST_ROM_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_space == SPACE_ROM) |=> $stable(ras_n)); // R8
  AST_EXT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_space != SPACE_DRAM && req_space != SPACE_ROM && !req_keep)
      |=> ras_n); // R6
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_space != SPACE_DRAM && req_space != SPACE_ROM && req_keep)
      |=> $stable(ras_n)); // R7
  AST_DONE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R9
endmodule

// File: tb/dram_row_seq_bench.sv
`timescale 1ns/1ps
module dram_row_seq_bench;
  localparam int ROW_W = 10;
  localparam int COL_W = 8;
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_space = 2'd0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_keep = 1'b0;
  logic req_ready, ras_n, cas_n, busy, done;
  logic [ADDR_W-1:0] addr_out;

  always #10 clk = ~clk;

  dram_row_seq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dram_row_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_space(req_space), .req_row(req_row), .req_col(req_col),
    .req_keep(req_keep), .ras_n(ras_n), .cas_n(cas_n), .addr_out(addr_out),
    .busy(busy), .done(done)
  );

  typedef struct { bit ras; bit cas; int addr; bit dn; int tag; } ent_t;
  ent_t q[$];
  int  tests = 0, fails = 0;
  bit  m_open = 0, m_first = 1;
  int  m_row = 0;

  function automatic string tname(int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      9: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tg, input string what, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tg, what, got, exp, $time);
    end
  endtask

  function automatic void push2(bit r, int a, int t, bit c2);
    ent_t e;
    e.ras = r; e.cas = 1; e.addr = a; e.dn = 0; e.tag = t; q.push_back(e);
    e.cas = !c2; e.dn = 1; q.push_back(e);
  endfunction

  function automatic void model_take(int s, int r, int c, bit k);
    ent_t e;
    if (s == 1) begin
      if (m_open && m_row == r) push2(0, c, 4, 1);
      else begin
        e.tag = m_first ? 10 : 3; e.dn = 0; e.cas = 1;
        e.ras = 1; e.addr = r; q.push_back(e);
        e.ras = 0; q.push_back(e);
        e.addr = c; q.push_back(e);
        e.cas = 0; e.dn = 1; q.push_back(e);
        m_open = 1; m_row = r;
      end
      m_first = 0;
    end else if (s == 2) push2(!m_open, c, 8, 0);
    else begin
      if (!k) m_open = 0;
      push2(!m_open, c, k ? 7 : 6, 0);
    end
  endfunction

  // per-cycle comparison against the behavioural model
  always @(negedge clk) begin
    ent_t e;
    bit busy_e, ready_e, acc;
    #1;
    if (rst_n) begin
      if (q.size() > 0) begin e = q[0]; busy_e = 1; end
      else begin e.ras = !m_open; e.cas = 1; e.addr = 0; e.dn = 0; e.tag = 2; busy_e = 0; end
      ready_e = (q.size() <= 1);
      chk(tname(e.tag), "ras_n", int'(ras_n), int'(e.ras));
      chk(tname(e.tag), "addr_out", int'(addr_out), e.addr);
      chk("R5", "cas_n", int'(cas_n), int'(e.cas));
      chk("R9", "done", int'(done), int'(e.dn));
      chk("R9", "busy", int'(busy), int'(busy_e));
      chk("R2", "req_ready", int'(req_ready), int'(ready_e));
      acc = req_valid && ready_e;
      if (q.size() > 0) void'(q.pop_front());
      if (acc) model_take(int'(req_space), int'(req_row), int'(req_col), req_keep);
    end
  end

  task automatic send(input int s, input int r, input int c, input bit k);
    @(negedge clk);
    req_valid = 1; req_space = 2'(s); req_row = ROW_W'(r);
    req_col = COL_W'(c); req_keep = k;
    #2;
    while (!req_ready) begin @(negedge clk); #2; end
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); req_valid = 0; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "ras_n", int'(ras_n), 1);
    chk("R1", "cas_n", int'(cas_n), 1);
    chk("R1", "req_ready", int'(req_ready), 1);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "addr_out", int'(addr_out), 0);
    @(negedge clk); rst_n = 1;
    gap(2);
    send(1, 5, 17, 0);      // R10 first DRAM access: full sequence
    send(1, 5, 18, 0);      // R4 back-to-back burst
    gap(3);
    send(1, 5, 19, 0);      // R4 burst after idle gap
    send(1, 6, 20, 0);      // R3 other row
    send(2, 0, 21, 0);      // R8 burst ROM keeps row
    send(1, 6, 22, 0);      // R8 following DRAM still bursts
    send(0, 0, 23, 1);      // R7 external with keep
    send(1, 6, 24, 0);      // R7 still bursts
    send(2, 0, 25, 1);      // R8 with keep bit set
    send(3, 0, 26, 0);      // R6 reserved code acts as external
    send(1, 6, 27, 0);      // R6 row closed: full sequence
    gap(2);
    send(0, 0, 28, 0);      // R6 idle release
    gap(2);
    send(2, 0, 29, 0);      // R8 ROM with row closed
    gap(2);
    for (int i = 0; i < 400; i++) begin
      send(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) gap(int'($urandom_range(1, 2)));
    end
    gap(8);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule